// File: doc/BRIEF.md
# Fixed-Frequency Half-Bridge Current Chopper

This block keeps the load current of a single half-bridge under a ceiling by chopping it at a fixed frequency. A drive request, taken from a register or a PWM pin, selects high side on, low side on, or off. While regulation is enabled, the block watches two digital flags for the conducting transistor. The first says the current is above its threshold. The second, used only while freewheeling, says the current has reached zero.

When the over-threshold flag stays high for longer than the selected filter time, the block declares a trip and sets a sticky status flag. For the rest of the chopping period it then does one of two things, chosen by a mode bit: it releases both gates, or it turns on the complementary transistor. If the block is freewheeling through the complementary transistor and the zero-current flag survives the same filter, both gates are released. At each period boundary the requested transistor is turned back on. Any change of the request starts a new period at once.

The time bases come from the clock frequency parameter `CLK_HZ`, which defaults to 1 MHz. Gate outputs are registered and take effect on the clock edge after the inputs that cause them. Comparators, thresholds, dead-time insertion and overcurrent shutdown are outside this block.

Top module: `fixed_freq_chopper`

## Requirements
- R1: During and right after reset, both gate outputs and the trip flag are low.
- R2: With the enable low, the gates follow the request on the next edge. Request code 01 drives the high side, 10 drives the low side, and 00 or 11 drive neither. No trip can be set while the enable is low. With the enable high and request 00, both gates are off.
- R3: The chopping period is (CLK_HZ/20000) << freq_sel_i cycles, which at 1 MHz gives 50, 100, 200 and 400 cycles. The edge that applies a new request is period cycle 0.
- R4: An over-threshold flag for the conducting transistor must be sampled high on D+1 consecutive edges before a trip is declared. D is CLK_HZ/500000, /200000, /100000 or /50000 for dg_sel_i codes 0 to 3, which at 1 MHz gives 2, 5, 10 and 20 cycles. A shorter pulse has no effect.
- R5: On a trip with fw_comp_i at 0, both gates turn off on the deciding edge and stay off until the period ends.
- R6: On a trip with fw_comp_i at 1, the requested gate turns off and the opposite gate turns on until the period ends.
- R7: At the period boundary, the requested gate turns back on and the other gate turns off.
- R8: A trip sets trip_o, which holds until trip_clr_i is sampled high. A trip on the same edge as a clear wins over the clear.
- R9: While freewheeling, if the zero-current flag of the freewheeling transistor is sampled high on D+1 consecutive edges, both gates turn off for the rest of the period.
- R10: A change of the request during a period restarts the period counter on that edge. Regulation continues on the newly requested transistor.
- R11: The high-side and low-side gates are never on together.
- R12: With the low side requested, the low-side over-threshold flag is monitored and the high side is the freewheel path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (CLK_HZ) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables chopping regulation |
| drive_i | input | 2 | Drive request: 00 off, 01 high side, 10 low side, 11 off |
| hs_oc_i | input | 1 | High-side current above threshold |
| ls_oc_i | input | 1 | Low-side current above threshold |
| hs_zc_i | input | 1 | High-side current at zero |
| ls_zc_i | input | 1 | Low-side current at zero |
| freq_sel_i | input | 2 | Chopping frequency code |
| dg_sel_i | input | 2 | Filter time code |
| fw_comp_i | input | 1 | 1 = complementary freewheel, 0 = both gates off |
| trip_clr_i | input | 1 | Clears the trip flag |
| hs_on_o | output | 1 | High-side gate enable |
| ls_on_o | output | 1 | Low-side gate enable |
| trip_o | output | 1 | Sticky trip status |

## Verification
The hardest case to reach is a restart in the middle of a freewheel interval. A plain timeout and a correct restart look the same unless the test holds the new period past the point where the old boundary would have fallen. The bench first trips the low side to start a freewheel interval. It changes the request to the high side twenty cycles into that period and trips again at once. It then checks that the complementary gate is still on at the edge where the old boundary would have been, and that the requested gate comes back only a full period after the change. The zero-current cut is reached the same way: a trip into complementary freewheel comes first, then the zero flag is held long enough to pass the filter.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
  localparam logic [1:0] DRV_OFF = 2'b00;
  localparam logic [1:0] DRV_HS  = 2'b01;
  localparam logic [1:0] DRV_LS  = 2'b10;

  typedef enum logic [1:0] {MD_DRIVE, MD_FREEWHEEL, MD_HIZ} mode_e;

  // chopping period in clock cycles: base 20 kHz, halved per code step
  function automatic int unsigned per_cycles(int unsigned clk_hz, logic [1:0] code);
    return (clk_hz / 20000) << code;
  endfunction

  // filter length in clock cycles: 2, 5, 10, 20 us
  function automatic int unsigned dg_cycles(int unsigned clk_hz, logic [1:0] code);
    case (code)
      2'd0:    return clk_hz / 500000;
      2'd1:    return clk_hz / 200000;
      2'd2:    return clk_hz / 100000;
      default: return clk_hz / 50000;
    endcase
  endfunction
endpackage

// File: rtl/ffc_period_ctr.sv
module ffc_period_ctr #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  // >= keeps a shortened period from overrunning after a code change
  assign wrap_o = (cnt_q >= lim_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clear_i || wrap_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ffc_deglitch.sv
module ffc_deglitch #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             flag_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  // fires on the (lim+1)-th consecutive high sample
  assign done_o = flag_i && (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (clear_i || !flag_i || done_o) cnt_q <= '0;
    else                                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fixed_freq_chopper.sv
module fixed_freq_chopper
  import ffc_pkg::*;
#(
  parameter int unsigned CLK_HZ = 1_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] drive_i,
  input  logic       hs_oc_i,
  input  logic       ls_oc_i,
  input  logic       hs_zc_i,
  input  logic       ls_zc_i,
  input  logic [1:0] freq_sel_i,
  input  logic [1:0] dg_sel_i,
  input  logic       fw_comp_i,
  input  logic       trip_clr_i,
  output logic       hs_on_o,
  output logic       ls_on_o,
  output logic       trip_o
);
  localparam int unsigned PER_MAX = per_cycles(CLK_HZ, 2'd3);
  localparam int unsigned PER_W   = $clog2(PER_MAX + 1);
  localparam int unsigned DG_MAX  = dg_cycles(CLK_HZ, 2'd3);
  localparam int unsigned DG_W    = $clog2(DG_MAX + 1);

  logic [1:0]       req_q;
  mode_e            mode_q, mode_n;
  logic             hs_q, ls_q, trip_q;
  logic             hs_n, ls_n, trip_set;
  logic             req_hs, req_ls, active, changed, restart;
  logic             wrap, dg_done, mon_flag;
  logic [PER_W-1:0] per_lim;
  logic [DG_W-1:0]  dg_lim;

  assign req_hs  = (drive_i == DRV_HS);
  assign req_ls  = (drive_i == DRV_LS);
  assign active  = en_i && (req_hs || req_ls);
  assign changed = (drive_i != req_q);
  assign restart = !active || changed;

  assign per_lim = PER_W'(per_cycles(CLK_HZ, freq_sel_i));
  assign dg_lim  = DG_W'(dg_cycles(CLK_HZ, dg_sel_i));

  ffc_period_ctr #(.CNT_W(PER_W)) u_period (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(restart),
    .lim_i  (per_lim),
    .wrap_o (wrap)
  );

  // monitored flag depends on which transistor currently conducts
  always_comb begin
    case (mode_q)
      MD_DRIVE:     mon_flag = req_hs ? hs_oc_i : ls_oc_i;
      MD_FREEWHEEL: mon_flag = req_hs ? ls_zc_i : hs_zc_i;
      default:      mon_flag = 1'b0;
    endcase
  end

  ffc_deglitch #(.CNT_W(DG_W)) u_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(restart || wrap),
    .flag_i (mon_flag),
    .lim_i  (dg_lim),
    .done_o (dg_done)
  );

  always_comb begin
    mode_n   = mode_q;
    trip_set = 1'b0;
    if (restart || wrap) begin
      mode_n = MD_DRIVE;
    end else if (dg_done) begin
      case (mode_q)
        MD_DRIVE: begin
          mode_n   = fw_comp_i ? MD_FREEWHEEL : MD_HIZ;
          trip_set = 1'b1;
        end
        MD_FREEWHEEL: mode_n = MD_HIZ;
        default:      mode_n = mode_q;
      endcase
    end

    hs_n = 1'b0;
    ls_n = 1'b0;
    if (!active) begin
      hs_n = req_hs;
      ls_n = req_ls;
    end else begin
      case (mode_n)
        MD_DRIVE:     begin hs_n = req_hs; ls_n = req_ls; end
        MD_FREEWHEEL: begin hs_n = req_ls; ls_n = req_hs; end
        default:      begin hs_n = 1'b0;   ls_n = 1'b0;   end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= DRV_OFF;
      mode_q <= MD_DRIVE;
      hs_q   <= 1'b0;
      ls_q   <= 1'b0;
      trip_q <= 1'b0;
    end else begin
      req_q  <= drive_i;
      mode_q <= mode_n;
      hs_q   <= hs_n;
      ls_q   <= ls_n;
      trip_q <= trip_set || (trip_q && !trip_clr_i);
    end
  end

  assign hs_on_o = hs_q;
  assign ls_on_o = ls_q;
  assign trip_o  = trip_q;
endmodule

// File: rtl/ffc_chk.sv
module ffc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [1:0] drive_i,
  input logic       fw_comp_i,
  input logic       trip_clr_i,
  input logic       hs_on_o,
  input logic       ls_on_o,
  input logic       trip_o
);
  AST_NO_SHOOT_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_on_o && ls_on_o)); // R11

  AST_TRIP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_o && !trip_clr_i) |=> trip_o); // R8

  AST_TRIP_CLR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_clr_i && !en_i) |=> !trip_o); // R8

  AST_IDLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (hs_on_o == ($past(drive_i) == 2'b01)) && (ls_on_o == ($past(drive_i) == 2'b10))); // R2

  AST_OFF_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_i == 2'b00) |=> (!hs_on_o && !ls_on_o)); // R2

  AST_TRIP_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(trip_o) && !$past(fw_comp_i)) |-> (!hs_on_o && !ls_on_o)); // R5

  AST_TRIP_COMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(trip_o) && $past(fw_comp_i)) |-> (hs_on_o != ls_on_o)); // R6
endmodule

bind fixed_freq_chopper ffc_chk u_ffc_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .drive_i   (drive_i),
  .fw_comp_i (fw_comp_i),
  .trip_clr_i(trip_clr_i),
  .hs_on_o   (hs_on_o),
  .ls_on_o   (ls_on_o),
  .trip_o    (trip_o)
);

// File: tb/fixed_freq_chopper_tb_top.sv
module fixed_freq_chopper_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [1:0] drive_i = 2'b00;
  logic       hs_oc_i = 1'b0, ls_oc_i = 1'b0, hs_zc_i = 1'b0, ls_zc_i = 1'b0;
  logic [1:0] freq_sel_i = 2'b00, dg_sel_i = 2'b00;
  logic       fw_comp_i = 1'b0, trip_clr_i = 1'b0;
  logic       hs_on_o, ls_on_o, trip_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fixed_freq_chopper dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .drive_i(drive_i),
    .hs_oc_i(hs_oc_i), .ls_oc_i(ls_oc_i), .hs_zc_i(hs_zc_i), .ls_zc_i(ls_zc_i),
    .freq_sel_i(freq_sel_i), .dg_sel_i(dg_sel_i), .fw_comp_i(fw_comp_i),
    .trip_clr_i(trip_clr_i), .hs_on_o(hs_on_o), .ls_on_o(ls_on_o), .trip_o(trip_o)
  );

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // gates packed as {hs,ls}
  task automatic chk_g(input string tag, input int exp);
    chk(tag, {30'd0, hs_on_o, ls_on_o}, exp);
  endtask

  task automatic fresh_start(input logic [1:0] req, input logic [1:0] fq,
                             input logic [1:0] dg, input logic fw);
    drive_i = 2'b00; edges(1);
    freq_sel_i = fq; dg_sel_i = dg; fw_comp_i = fw; en_i = 1'b1;
    drive_i = req; edges(1);
  endtask

  task automatic t_reset;
    edges(3);
    chk_g("R1 gates in reset", 0);
    chk("R1 trip in reset", trip_o, 0);
    rst_ni = 1'b1; edges(1);
    chk_g("R1 gates after reset", 0);
    chk("R1 trip after reset", trip_o, 0);
  endtask

  task automatic t_idle;
    en_i = 1'b0; drive_i = 2'b10; ls_oc_i = 1'b1; edges(1);
    chk_g("R2 disabled LS pass", 1);
    edges(30);
    chk_g("R2 disabled LS held under oc", 1);
    chk("R2 no trip when disabled", trip_o, 0);
    ls_oc_i = 1'b0;
    drive_i = 2'b11; edges(1);
    chk_g("R2 code 11 off", 0);
    drive_i = 2'b01; edges(1);
    chk_g("R2 disabled HS pass", 2);
    en_i = 1'b1; drive_i = 2'b00; edges(1);
    chk_g("R2 enabled request off", 0);
  endtask

  task automatic t_trip_hiz;
    fresh_start(2'b01, 2'b00, 2'b00, 1'b0);
    chk_g("R3 HS on at period start", 2);
    hs_oc_i = 1'b1; edges(2);
    chk_g("R4 no trip before D+1 samples", 2);
    edges(1);
    chk_g("R5 hi-z after trip", 0);
    chk("R8 trip set", trip_o, 1);
    hs_oc_i = 1'b0; edges(46);
    chk_g("R5 hi-z holds to period end", 0);
    edges(1);
    chk_g("R7 HS back at 50-cycle boundary", 2);
    chk("R8 trip sticky", trip_o, 1);
    trip_clr_i = 1'b1; edges(1); trip_clr_i = 1'b0;
    chk("R8 trip cleared", trip_o, 0);
  endtask

  task automatic t_glitch;
    fresh_start(2'b01, 2'b00, 2'b00, 1'b0);
    hs_oc_i = 1'b1; edges(2); hs_oc_i = 1'b0; edges(5);
    chk_g("R4 short pulse ignored gates", 2);
    chk("R4 short pulse no trip", trip_o, 0);
  endtask

  task automatic t_freewheel;
    fresh_start(2'b01, 2'b01, 2'b01, 1'b1);
    hs_oc_i = 1'b1; edges(5);
    chk_g("R4 D=5 not yet tripped", 2);
    edges(1);
    chk_g("R6 complementary LS on", 1);
    hs_oc_i = 1'b0; edges(93);
    chk_g("R3 freewheel holds to cycle 99", 1);
    edges(1);
    chk_g("R7 HS back at 100-cycle boundary", 2);
    hs_oc_i = 1'b1; edges(6); hs_oc_i = 1'b0;
    chk_g("R6 second trip freewheel", 1);
    ls_zc_i = 1'b1; edges(5);
    chk_g("R9 zero flag still filtered", 1);
    edges(1);
    chk_g("R9 zero current cuts to hi-z", 0);
    ls_zc_i = 1'b0;
  endtask

  task automatic t_restart;
    fresh_start(2'b10, 2'b01, 2'b01, 1'b1);
    chk_g("R12 LS requested", 1);
    ls_oc_i = 1'b1; edges(6); ls_oc_i = 1'b0;
    chk_g("R12 LS trip freewheels on HS", 2);
    edges(14);
    drive_i = 2'b01; edges(1);
    chk_g("R10 new request applied", 2);
    hs_oc_i = 1'b1; edges(6); hs_oc_i = 1'b0;
    chk_g("R10 trip after restart", 1);
    edges(73);
    chk_g("R10 old boundary ignored", 1);
    edges(21);
    chk_g("R10 boundary one period after change", 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_trip_hiz();
    t_glitch();
    t_freewheel();
    t_restart();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule